// File: doc/BRIEF.md
# SMBus Host Controller Register Front End

This block is the byte-wide register file that software uses to run an SMBus host controller. It holds a status byte, a control byte, a command byte, a target address byte, two data bytes and a block buffer. The block buffer is reached through a single data port whose index advances on every access. Software loads the command, the address and the data. It then writes the control byte with the start bit set. The front end turns the protocol code and the direction bit into a request for a separate bit-level bus engine. When the engine acknowledges, the front end stores any returned data into the data registers.

The engine interface is a level request held until a one-cycle acknowledge. The request carries a copy of the transaction fields, taken at the moment of the start. Software may therefore rewrite the registers while the transfer is in flight. The engine reaches the block buffer through its own index, write strobe and read data pins. It uses them to fetch bytes for a block write and to deposit bytes for a block read.

The bit-level engine is not part of this block. A protocol code the front end does not support is never sent to the engine: the front end raises an error flag in the status byte instead.

Top module: `smb_host_regs`

## Requirements
- R1: After a synchronous reset, the following all read 0: status, control, command, address, data0, data1 and every block buffer entry. The request is low and the block index is 0.
- R2: Offsets 0x03 (command), 0x04 (address), 0x05 (data0) and 0x06 (data1) store the written byte and read it back unchanged. Offset 0x01 and offsets 0x08 to 0x3F always read 0, and writes to them change no register.
- R3: A write to offset 0x02 stores all eight control bits. A read of offset 0x02 returns control bits 4:0 with bits 7:5 as 0, and that read also returns the block index to 0.
- R4: A control write with bit 6 set and a supported protocol code in bits 4:2 raises the request from the next cycle on. The supported codes are 0 (quick), 1 (send/receive byte), 2 (byte with command), 3 (word with command) and 5 (block). With the request, the block presents the protocol code, the direction taken from address bit 0 (1 = read), the target taken from address bits 7:1, the command byte, and write data {data1, data0}. These values stay held until the acknowledge.
- R5: A start with protocol code 4, 6 or 7 sets status bit 2 and raises no request.
- R6: Any write to offset 0x00 clears the whole status byte and returns the block index to 0.
- R7: While a request is pending, a further start is ignored: the presented fields stay unchanged, no error is flagged, and the request falls after the one acknowledge.
- R8: On acknowledge of a read, the block stores returned data as follows. Codes 1 and 2 store return bits 7:0 into data0. Code 3 stores bits 7:0 into data0 and bits 15:8 into data1. Code 5 stores the block count from bits 7:0 into data0. Writes and quick commands leave data0 and data1 unchanged.
- R9: Each access to offset 0x07 reads or writes the buffer entry at the block index and then advances the index. The index wraps to 0 after entry 31.
- R10: The engine-side buffer read data shows the entry at the engine index, and an engine write strobe stores a byte at that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (applies side effects) |
| reg_addr | input | 6 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the current offset |
| eng_req | output | 1 | Transaction request to the bus engine |
| eng_proto | output | 3 | Protocol code of the pending request |
| eng_rd | output | 1 | Direction of the pending request, 1 = read |
| eng_tgt | output | 7 | Seven-bit target address |
| eng_cmd | output | 8 | Command byte |
| eng_wdata | output | 16 | Write data {data1, data0}; block byte count in low byte |
| eng_ack | input | 1 | Engine completion, one cycle |
| eng_rdata | input | 16 | Engine return data, valid with eng_ack |
| eng_buf_idx | input | 5 | Engine-side block buffer index |
| eng_buf_we | input | 1 | Engine-side buffer write strobe |
| eng_buf_wdata | input | 8 | Engine-side buffer write data |
| eng_buf_rdata | output | 8 | Engine-side buffer read data |

## Verification
The bench builds the block with its default parameters: a six-bit offset space and a 32-entry buffer. These values are small enough for exhaustive sweeps. The bench reads every one of the 64 offsets. It runs all eight protocol codes in both directions, and it drives the buffer index past its wrap point. Expected data bytes, targets and buffer contents are derived arithmetically from the loop counters. A simple responder in the bench stands in for the bus engine.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

    localparam int REG_AW = 6;

    localparam logic [REG_AW-1:0] OFS_STAT = 6'h00;
    localparam logic [REG_AW-1:0] OFS_CTL  = 6'h02;
    localparam logic [REG_AW-1:0] OFS_CMD  = 6'h03;
    localparam logic [REG_AW-1:0] OFS_ADR  = 6'h04;
    localparam logic [REG_AW-1:0] OFS_D0   = 6'h05;
    localparam logic [REG_AW-1:0] OFS_D1   = 6'h06;
    localparam logic [REG_AW-1:0] OFS_BLK  = 6'h07;

    localparam int START_BIT = 6;
    localparam int ERR_BIT   = 2;

    typedef enum logic [2:0] {
        PR_QUICK = 3'd0,
        PR_BYTE  = 3'd1,
        PR_BDATA = 3'd2,
        PR_WORD  = 3'd3,
        PR_BLOCK = 3'd5
    } proto_e;

    typedef struct packed {
        logic [2:0]  proto;
        logic        rd;
        logic [6:0]  tgt;
        logic [7:0]  cmd;
        logic [15:0] wdata;
    } xfer_t;

    function automatic logic proto_ok(input logic [2:0] code);
        return (code == PR_QUICK) || (code == PR_BYTE) || (code == PR_BDATA) ||
               (code == PR_WORD)  || (code == PR_BLOCK);
    endfunction

endpackage

// File: rtl/smb_proto_decode.sv
module smb_proto_decode
    import smb_host_pkg::*;
(
    input  logic [7:0]  ctl_in,
    input  logic [7:0]  adr_q,
    input  logic [7:0]  cmd_q,
    input  logic [7:0]  d0_q,
    input  logic [7:0]  d1_q,
    input  xfer_t       cur,
    input  logic [15:0] ret_data,
    output xfer_t       nxt,
    output logic        start,
    output logic        supported,
    output logic        upd_d0,
    output logic        upd_d1,
    output logic [7:0]  new_d0,
    output logic [7:0]  new_d1
);
    always_comb begin
        start      = ctl_in[START_BIT];
        supported  = proto_ok(ctl_in[4:2]);
        nxt.proto  = ctl_in[4:2];
        nxt.rd     = adr_q[0];
        nxt.tgt    = adr_q[7:1];
        nxt.cmd    = cmd_q;
        nxt.wdata  = {d1_q, d0_q};
    end

    always_comb begin
        upd_d0 = 1'b0;
        upd_d1 = 1'b0;
        new_d0 = ret_data[7:0];
        new_d1 = ret_data[15:8];
        if (cur.rd) begin
            unique case (cur.proto)
                PR_BYTE, PR_BDATA, PR_BLOCK: upd_d0 = 1'b1;
                PR_WORD: begin
                    upd_d0 = 1'b1;
                    upd_d1 = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/smb_blk_buf.sv
module smb_blk_buf #(
    parameter int DEPTH = 32,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_we,
    input  logic          host_re,
    input  logic [7:0]    host_wdata,
    input  logic          idx_clr,
    output logic [7:0]    host_rdata,
    input  logic [IW-1:0] eng_idx,
    input  logic          eng_we,
    input  logic [7:0]    eng_wdata,
    output logic [7:0]    eng_rdata
);
    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    logic [7:0]    mem [DEPTH];
    logic [IW-1:0] idx;
    logic          step;

    assign step       = host_we || host_re;
    assign host_rdata = mem[idx];
    assign eng_rdata  = mem[eng_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (idx_clr) begin
            idx <= '0;
        end else if (step) begin
            idx <= (idx == LAST) ? '0 : idx + 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= '0;
            else if (eng_we && eng_idx == IW'(g))
                mem[g] <= eng_wdata;
            else if (host_we && idx == IW'(g))
                mem[g] <= host_wdata;
        end
    end

    // R9
    idx_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !idx_clr && idx == LAST) |=> (idx == '0));

    // R3
    idx_clr_chk: assert property (@(posedge clk) disable iff (rst)
        idx_clr |=> (idx == '0));
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
    import smb_host_pkg::*;
#(
    parameter int ADDR_W    = REG_AW,
    parameter int BLK_DEPTH = 32,
    localparam int BIW      = $clog2(BLK_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              eng_req,
    output logic [2:0]        eng_proto,
    output logic              eng_rd,
    output logic [6:0]        eng_tgt,
    output logic [7:0]        eng_cmd,
    output logic [15:0]       eng_wdata,
    input  logic              eng_ack,
    input  logic [15:0]       eng_rdata,
    input  logic [BIW-1:0]    eng_buf_idx,
    input  logic              eng_buf_we,
    input  logic [7:0]        eng_buf_wdata,
    output logic [7:0]        eng_buf_rdata
);
    logic [7:0] stat_q, ctl_q, cmd_q, adr_q, d0_q, d1_q;
    logic       busy_q;
    xfer_t      xfer_q, xfer_n;
    logic       start, supported, upd_d0, upd_d1;
    logic [7:0] new_d0, new_d1, blk_rdata;

    logic wr_stat, wr_ctl, rd_ctl, wr_blk, rd_blk;
    assign wr_stat = reg_wr && reg_addr == ADDR_W'(OFS_STAT);
    assign wr_ctl  = reg_wr && reg_addr == ADDR_W'(OFS_CTL);
    assign rd_ctl  = reg_rd && reg_addr == ADDR_W'(OFS_CTL);
    assign wr_blk  = reg_wr && reg_addr == ADDR_W'(OFS_BLK);
    assign rd_blk  = reg_rd && reg_addr == ADDR_W'(OFS_BLK);

    smb_proto_decode u_dec (
        .ctl_in    (reg_wdata),
        .adr_q     (adr_q),
        .cmd_q     (cmd_q),
        .d0_q      (d0_q),
        .d1_q      (d1_q),
        .cur       (xfer_q),
        .ret_data  (eng_rdata),
        .nxt       (xfer_n),
        .start     (start),
        .supported (supported),
        .upd_d0    (upd_d0),
        .upd_d1    (upd_d1),
        .new_d0    (new_d0),
        .new_d1    (new_d1)
    );

    smb_blk_buf #(.DEPTH(BLK_DEPTH)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .host_we    (wr_blk),
        .host_re    (rd_blk),
        .host_wdata (reg_wdata),
        .idx_clr    (wr_stat || rd_ctl),
        .host_rdata (blk_rdata),
        .eng_idx    (eng_buf_idx),
        .eng_we     (eng_buf_we),
        .eng_wdata  (eng_buf_wdata),
        .eng_rdata  (eng_buf_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            ctl_q  <= '0;
            cmd_q  <= '0;
            adr_q  <= '0;
            d0_q   <= '0;
            d1_q   <= '0;
            busy_q <= 1'b0;
            xfer_q <= '0;
        end else begin
            if (reg_wr) begin
                unique case (reg_addr)
                    ADDR_W'(OFS_STAT): stat_q <= '0;
                    ADDR_W'(OFS_CTL): begin
                        ctl_q <= reg_wdata;
                        if (start && !busy_q) begin
                            if (supported) begin
                                busy_q <= 1'b1;
                                xfer_q <= xfer_n;
                            end else begin
                                stat_q[ERR_BIT] <= 1'b1;
                            end
                        end
                    end
                    ADDR_W'(OFS_CMD): cmd_q <= reg_wdata;
                    ADDR_W'(OFS_ADR): adr_q <= reg_wdata;
                    ADDR_W'(OFS_D0):  d0_q  <= reg_wdata;
                    ADDR_W'(OFS_D1):  d1_q  <= reg_wdata;
                    default: ;
                endcase
            end
            if (busy_q && eng_ack) begin
                busy_q <= 1'b0;
                if (upd_d0) d0_q <= new_d0;
                if (upd_d1) d1_q <= new_d1;
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_W'(OFS_STAT): reg_rdata = stat_q;
            ADDR_W'(OFS_CTL):  reg_rdata = {3'b000, ctl_q[4:0]};
            ADDR_W'(OFS_CMD):  reg_rdata = cmd_q;
            ADDR_W'(OFS_ADR):  reg_rdata = adr_q;
            ADDR_W'(OFS_D0):   reg_rdata = d0_q;
            ADDR_W'(OFS_D1):   reg_rdata = d1_q;
            ADDR_W'(OFS_BLK):  reg_rdata = blk_rdata;
            default:           reg_rdata = '0;
        endcase
    end

    assign eng_req   = busy_q;
    assign eng_proto = xfer_q.proto;
    assign eng_rd    = xfer_q.rd;
    assign eng_tgt   = xfer_q.tgt;
    assign eng_cmd   = xfer_q.cmd;
    assign eng_wdata = xfer_q.wdata;

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_req && !eng_ack) |=> (eng_req && $stable(eng_proto) &&
                                   $stable(eng_tgt) && $stable(eng_cmd)));

    // R4
    req_proto_chk: assert property (@(posedge clk) disable iff (rst)
        eng_req |-> proto_ok(eng_proto));

    // R5
    bad_proto_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && reg_wdata[START_BIT] && !eng_req && !proto_ok(reg_wdata[4:2]))
        |=> (!eng_req && stat_q[ERR_BIT]));

    // R7
    busy_ign_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_req && !eng_ack && wr_ctl) |=> ($stable(eng_proto) && $stable(stat_q)));

    // R6
    stat_clr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stat |=> (stat_q == 8'h00));
endmodule

// File: tb/smb_host_regs_bench.sv
module smb_host_regs_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr, reg_rd;
    logic [5:0]  reg_addr;
    logic [7:0]  reg_wdata, reg_rdata;
    logic        eng_req, eng_rd, eng_ack, eng_buf_we;
    logic [2:0]  eng_proto;
    logic [6:0]  eng_tgt;
    logic [7:0]  eng_cmd, eng_buf_wdata, eng_buf_rdata;
    logic [15:0] eng_wdata, eng_rdata;
    logic [4:0]  eng_buf_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    smb_host_regs u_smb_host_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_req(eng_req), .eng_proto(eng_proto), .eng_rd(eng_rd),
        .eng_tgt(eng_tgt), .eng_cmd(eng_cmd), .eng_wdata(eng_wdata),
        .eng_ack(eng_ack), .eng_rdata(eng_rdata), .eng_buf_idx(eng_buf_idx),
        .eng_buf_we(eng_buf_we), .eng_buf_wdata(eng_buf_wdata),
        .eng_buf_rdata(eng_buf_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic ack(input logic [15:0] r);
        @(negedge clk);
        eng_ack = 1'b1; eng_rdata = r;
        @(negedge clk);
        eng_ack = 1'b0;
    endtask

    task automatic eng_put(input logic [4:0] i, input logic [7:0] d);
        @(negedge clk);
        eng_buf_we = 1'b1; eng_buf_idx = i; eng_buf_wdata = d;
        @(negedge clk);
        eng_buf_we = 1'b0;
    endtask

    function automatic bit ok_code(input int c);
        return c == 0 || c == 1 || c == 2 || c == 3 || c == 5;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
        eng_ack = 0; eng_rdata = 0; eng_buf_idx = 0; eng_buf_we = 0; eng_buf_wdata = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state across all offsets and the buffer
        for (int a = 0; a < 64; a++) begin
            rd(6'(a), v);
            chk(v == 8'h00, "R1", v, 0);
        end
        chk(eng_req == 1'b0, "R1", eng_req, 0);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk); eng_buf_idx = 5'(i); #1;
            chk(eng_buf_rdata == 8'h00, "R1", eng_buf_rdata, 0);
        end

        // R2: plain registers and undefined offsets
        wr(6'h03, 8'hA3); wr(6'h04, 8'hB4); wr(6'h05, 8'hC5); wr(6'h06, 8'hD6);
        for (int a = 8; a < 64; a++) wr(6'(a), 8'hFF);
        wr(6'h01, 8'hFF);
        for (int a = 0; a < 64; a++) begin
            int e;
            rd(6'(a), v);
            case (a)
                3: e = 8'hA3; 4: e = 8'hB4; 5: e = 8'hC5; 6: e = 8'hD6;
                default: e = 0;
            endcase
            chk(v == 8'(e), "R2", v, e);
        end

        // R3: control readback masks bits 7:5
        wr(6'h02, 8'hBF & ~8'h40);
        rd(6'h02, v);
        chk(v == 8'h1F, "R3", v, 8'h1F);
        chk(eng_req == 1'b0, "R3", eng_req, 0);

        // R4 R5 R8: sweep all protocol codes and both directions
        for (int code = 0; code < 8; code++) begin
            for (int dir = 0; dir < 2; dir++) begin
                logic [6:0] tgt;
                logic [7:0] cmd, d0i, d1i, lo, hi;
                int e0, e1;
                tgt = 7'((code * 13 + dir * 5 + 3) & 127);
                cmd = 8'(code * 17 + 1);
                d0i = 8'(8'h30 + code); d1i = 8'(8'h60 + dir);
                lo  = 8'(8'h80 + code * 2 + dir); hi = 8'(8'hC0 + code);
                wr(6'h00, 8'h00);
                wr(6'h04, {tgt, 1'(dir)}); wr(6'h03, cmd);
                wr(6'h05, d0i); wr(6'h06, d1i);
                wr(6'h02, 8'(8'h40 | (code << 2)));
                if (ok_code(code)) begin
                    chk(eng_req == 1'b1, "R4", eng_req, 1);
                    chk(eng_proto == 3'(code), "R4", eng_proto, code);
                    chk(eng_rd == 1'(dir), "R4", eng_rd, dir);
                    chk(eng_tgt == tgt, "R4", eng_tgt, tgt);
                    chk(eng_cmd == cmd, "R4", eng_cmd, cmd);
                    chk(eng_wdata == {d1i, d0i}, "R4", eng_wdata, {d1i, d0i});
                    if (code == 5 && dir == 1)
                        for (int i = 0; i < 4; i++) eng_put(5'(i), 8'(8'hE0 + i));
                    chk(eng_req == 1'b1, "R4", eng_req, 1);
                    ack({hi, lo});
                    chk(eng_req == 1'b0, "R8", eng_req, 0);
                    rd(6'h00, v);
                    chk(v == 8'h00, "R4", v, 0);
                end else begin
                    chk(eng_req == 1'b0, "R5", eng_req, 0);
                    rd(6'h00, v);
                    chk(v == 8'h04, "R5", v, 4);
                end
                e0 = (dir == 1 && ok_code(code) && code != 0) ? lo : d0i;
                e1 = (dir == 1 && code == 3) ? hi : d1i;
                rd(6'h05, v); chk(v == 8'(e0), "R8", v, e0);
                rd(6'h06, v); chk(v == 8'(e1), "R8", v, e1);
                if (code == 5 && dir == 1) begin
                    rd(6'h02, v);
                    for (int i = 0; i < 4; i++) begin
                        rd(6'h07, v);
                        chk(v == 8'(8'hE0 + i), "R10", v, 8'hE0 + i);
                    end
                end
            end
        end

        // R6: status write clears error
        wr(6'h02, 8'h40 | (8'd7 << 2));
        rd(6'h00, v); chk(v == 8'h04, "R5", v, 4);
        wr(6'h00, 8'h00);
        rd(6'h00, v); chk(v == 8'h00, "R6", v, 0);

        // R7: starts while busy are ignored
        wr(6'h04, 8'h22);
        wr(6'h02, 8'h40 | (8'd2 << 2));
        wr(6'h02, 8'h40 | (8'd3 << 2));
        chk(eng_proto == 3'd2, "R7", eng_proto, 2);
        wr(6'h02, 8'h40 | (8'd6 << 2));
        rd(6'h00, v); chk(v == 8'h00, "R7", v, 0);
        chk(eng_req == 1'b1, "R7", eng_req, 1);
        ack(16'h0000);
        @(negedge clk);
        chk(eng_req == 1'b0, "R7", eng_req, 0);

        // R9: 34 writes wrap the index over entries 0 and 1
        wr(6'h00, 8'h00);
        for (int i = 0; i < 34; i++) wr(6'h07, 8'(i * 7 + 1));
        rd(6'h02, v);
        for (int i = 0; i < 32; i++) begin
            int e;
            e = (i < 2) ? ((32 + i) * 7 + 1) & 255 : (i * 7 + 1) & 255;
            rd(6'h07, v);
            chk(v == 8'(e), "R9", v, e);
        end
        rd(6'h07, v);
        chk(v == 8'(((32) * 7 + 1) & 255), "R9", v, ((32) * 7 + 1) & 255);

        // R3 and R6: index reset by control read and by status write
        rd(6'h07, v); rd(6'h07, v);
        rd(6'h02, v);
        rd(6'h07, v); chk(v == 8'(((32) * 7 + 1) & 255), "R3", v, ((32) * 7 + 1) & 255);
        rd(6'h07, v);
        wr(6'h00, 8'h00);
        rd(6'h07, v); chk(v == 8'(((32) * 7 + 1) & 255), "R6", v, ((32) * 7 + 1) & 255);

        // R10: engine-side view of host-written entries
        @(negedge clk); eng_buf_idx = 5'd9; #1;
        chk(eng_buf_rdata == 8'(9 * 7 + 1), "R10", eng_buf_rdata, 9 * 7 + 1);
        eng_put(5'd9, 8'h5A);
        wr(6'h00, 8'h00);
        for (int i = 0; i < 9; i++) rd(6'h07, v);
        rd(6'h07, v); chk(v == 8'h5A, "R10", v, 8'h5A);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule